// File: doc/BRIEF.md
# Recirculating Echo Mixer

This block adds a feedback echo to a stream of signed audio samples. It keeps a circular delay memory whose depth is set by a parameter. For a few tens of milliseconds of audio, that depth is a few thousand entries.

Each accepted sample is handled in the same way:

- The block reads the word stored at the current slot of the memory.
- It blends the new sample with that old word. The new sample is weighted by a programmable coefficient k, and the old word by the full-scale complement of k.
- It writes the blend back into the same slot and moves the slot pointer forward by one, modulo the depth.

The blend is also the output sample. Because the memory holds past outputs rather than raw inputs, each echo feeds back into later echoes. Only one pointer is needed.

The coefficient is an unsigned fraction with COEF_W bits. The value 2^COEF_W stands for 1.0, so a coefficient of 0 gives a pure recirculating delay. After reset, the memory contents are ignored until the pointer has wrapped once. Each output sample leaves the block two clock cycles after the sample that produced it.

Top module: `echo_mixer`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, out_valid is low.
- R2: out_valid equals in_valid delayed by exactly two clock cycles. An output sample is presented only when out_valid is high.
- R3: out_sample = floor((x*k + old*(2^COEF_W - k) + 2^(COEF_W-1)) / 2^COEF_W). Here x is the signed input sample, k is the unsigned coefficient and old is the stored word. The result is saturated to the signed SAMPLE_W range.
- R4: For the first DEPTH accepted samples after reset, the stored word is taken as zero.
- R5: The word written into a slot is the output sample produced for that slot. Accepted sample number n+DEPTH therefore blends with output number n.
- R6: The slot pointer moves only on accepted samples. Idle cycles leave the delay, counted in samples, unchanged.
- R7: The pointer wraps from DEPTH-1 back to 0, so the delay stays at DEPTH samples over many laps.
- R8: With k = 0, each output equals the output produced DEPTH samples earlier (zero during the first lap).
- R9: mix_coef is sampled only in the cycle where in_valid is high. Its value in idle cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | SAMPLE_W | Signed input sample |
| mix_coef | input | COEF_W | Unsigned fractional weight for the new sample |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | SAMPLE_W | Signed blended output sample |

## Verification
Two events can fall in the same cycle: the write-back of one sample's blend and the read of the next sample's slot. This happens whenever samples arrive back to back. The bench provokes it with unbroken runs over several laps. It also runs with idle gaps between samples, and at the wrap point, where the read slot returns to 0.

The outcome is judged against a model that stores each expected output and replays it DEPTH accepted samples later. A read that picked up a stale or wrong word would give a mismatch on the next lap.

// File: rtl/echo_pkg.sv
package echo_pkg;

  // Weighted sum at full precision: x*k + old*(2^cw - k)
  function automatic longint blend_full(longint x, longint old, longint k, int cw);
    return x * k + old * ((longint'(1) <<< cw) - k);
  endfunction

  // Round half up, then drop cw fractional bits (arithmetic shift)
  function automatic longint round_drop(longint v, int cw);
    return (v + (longint'(1) <<< (cw - 1))) >>> cw;
  endfunction

  // Clamp to the signed range of w bits
  function automatic longint clamp_signed(longint v, int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/echo_slot_ctr.sv
module echo_slot_ctr #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic          filled
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      filled <= 1'b0;
    end else if (adv) begin
      if (ptr == LAST) begin
        ptr    <= '0;
        filled <= 1'b1;
      end else begin
        ptr <= ptr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/echo_delay_mem.sv
module echo_delay_mem #(
  parameter int DEPTH = 32,
  parameter int SW    = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  input  logic          filled,
  output logic [SW-1:0] rd_word,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [SW-1:0] wr_data
);
  logic [SW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Contents before the first wrap are treated as silence
  assign rd_word = filled ? store[rd_addr] : '0;
endmodule

// File: rtl/echo_blend.sv
module echo_blend #(
  parameter int SW = 16,
  parameter int CW = 8
) (
  input  logic signed [SW-1:0] x,
  input  logic signed [SW-1:0] old,
  input  logic        [CW-1:0] k,
  output logic signed [SW-1:0] y
);
  import echo_pkg::*;

  longint full_sum;
  longint rounded;
  longint limited;

  always_comb begin
    full_sum = blend_full(longint'(x), longint'(old), longint'({1'b0, k}), CW);
    rounded  = round_drop(full_sum, CW);
    limited  = clamp_signed(rounded, SW);
    y        = SW'(limited);
  end
endmodule

// File: rtl/echo_mixer.sv
module echo_mixer #(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 8,
  parameter int DEPTH    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic        [COEF_W-1:0]   mix_coef,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_sample
);
  localparam int AW = $clog2(DEPTH);

  // Named internal events
  logic                       adv;
  logic [AW-1:0]              ptr;
  logic                       filled;
  logic [SAMPLE_W-1:0]        old_word;
  logic                       wr_en;
  logic signed [SAMPLE_W-1:0] wr_data;

  // Stage 1 registers
  logic                       s1_valid;
  logic signed [SAMPLE_W-1:0] s1_x;
  logic signed [SAMPLE_W-1:0] s1_old;
  logic        [COEF_W-1:0]   s1_k;
  logic [AW-1:0]              s1_addr;

  assign adv = in_valid;

  echo_slot_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .ptr    (ptr),
    .filled (filled)
  );

  echo_delay_mem #(.DEPTH(DEPTH), .SW(SAMPLE_W)) u_mem (
    .clk     (clk),
    .rd_addr (ptr),
    .filled  (filled),
    .rd_word (old_word),
    .wr_en   (wr_en),
    .wr_addr (s1_addr),
    .wr_data (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_x     <= '0;
      s1_old   <= '0;
      s1_k     <= '0;
      s1_addr  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_x    <= in_sample;
        s1_old  <= old_word;
        s1_k    <= mix_coef;
        s1_addr <= ptr;
      end
    end
  end

  echo_blend #(.SW(SAMPLE_W), .CW(COEF_W)) u_blend (
    .x   (s1_x),
    .old (s1_old),
    .k   (s1_k),
    .y   (wr_data)
  );

  assign wr_en = s1_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_sample <= wr_data;
    end
  end
endmodule

// File: rtl/echo_mixer_chk.sv
module echo_mixer_chk #(
  parameter int SW    = 16,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [AW-1:0] ptr,
  input logic          adv,
  input logic          filled,
  input logic [SW-1:0] old_word,
  input logic          wr_en,
  input logic [SW-1:0] wr_data,
  input logic [SW-1:0] out_sample
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R2
  AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid); // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == AW'(DEPTH - 1)) |=> (ptr == '0)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr)); // R6
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !filled |-> (old_word == '0)); // R4
  AST_STORE_IS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (out_sample == $past(wr_data))); // R5
endmodule

bind echo_mixer echo_mixer_chk #(.SW(SAMPLE_W), .DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .ptr        (ptr),
  .adv        (adv),
  .filled     (filled),
  .old_word   (old_word),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .out_sample (out_sample)
);

// File: tb/echo_mixer_tb.sv
module echo_mixer_tb;
  localparam int SW = 16;
  localparam int CW = 8;
  localparam int DEPTH = 32;
  localparam int CLK_PERIOD = 10;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [SW-1:0] in_sample = '0;
  logic        [CW-1:0] mix_coef = '0;
  logic                 out_valid;
  logic signed [SW-1:0] out_sample;

  int checks = 0;
  int failures = 0;

  // Model state
  longint hist [DEPTH];
  int     n_acc = 0;
  logic   ev [2];
  longint eval_q [2];

  always #(CLK_PERIOD / 2) clk = ~clk;

  echo_mixer #(.SAMPLE_W(SW), .COEF_W(CW), .DEPTH(DEPTH)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .mix_coef   (mix_coef),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  // Expected blend: floor division written without shifts
  function automatic longint model_mix(longint x, longint old, longint k);
    longint num;
    longint q;
    num = x * k + old * (256 - k) + 128;
    if (num >= 0) q = num / 256;
    else q = -((-num + 255) / 256);
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  function automatic logic signed [SW-1:0] pat(int i, int salt);
    longint v;
    v = ((longint'(i) * 7919 + longint'(salt) * 104729 + 123) % 65536) - 32768;
    return SW'(v);
  endfunction

  task automatic step(input logic v, input logic signed [SW-1:0] x,
                      input logic [CW-1:0] k, input string tag);
    longint old;
    @(negedge clk);
    checks++;
    if (out_valid !== ev[1]) begin
      failures++;
      $display("FAIL R2 (%s) out_valid=%0b expected=%0b", tag, out_valid, ev[1]);
    end
    if (ev[1]) begin
      checks++;
      if (longint'(out_sample) != eval_q[1]) begin
        failures++;
        $display("FAIL %s out_sample=%0d expected=%0d", tag, out_sample, eval_q[1]);
      end
    end
    ev[1] = ev[0];
    eval_q[1] = eval_q[0];
    ev[0] = v;
    if (v) begin
      old = (n_acc < DEPTH) ? 0 : hist[n_acc % DEPTH];
      eval_q[0] = model_mix(longint'(x), old, longint'(k));
      hist[n_acc % DEPTH] = eval_q[0];
      n_acc++;
    end
    in_valid = v;
    in_sample = x;
    mix_coef = k;
  endtask

  task automatic flush(input string tag);
    step(1'b0, '0, '0, tag);
    step(1'b0, '0, '0, tag);
    step(1'b0, '0, '0, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 out_valid=%0b expected=0 during reset", out_valid);
    end
    rst_n = 1'b1;
    n_acc = 0;
    ev[0] = 1'b0; ev[1] = 1'b0;
    eval_q[0] = 0; eval_q[1] = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 out_valid=%0b expected=0 after reset", out_valid);
    end
  endtask

  // First lap: stored words read as zero
  task automatic t_first_lap();
    for (int i = 0; i < DEPTH; i++) step(1'b1, pat(i, 1), 8'd255, "R4");
    flush("R4");
  endtask

  // Second lap blends with first-lap outputs
  task automatic t_feedback();
    for (int i = 0; i < DEPTH; i++) step(1'b1, pat(i, 2), 8'd128, "R5");
    flush("R5");
  endtask

  // Extreme values and rounding
  task automatic t_round();
    step(1'b1, 16'sh7FFF, 8'd255, "R3");
    step(1'b1, 16'sh8000, 8'd255, "R3");
    step(1'b1, 16'sh8000, 8'd1, "R3");
    step(1'b1, 16'sh7FFF, 8'd1, "R3");
    step(1'b1, -16'sd1, 8'd128, "R3");
    step(1'b1, 16'sd1, 8'd128, "R3");
    step(1'b1, -16'sd3, 8'd64, "R3");
    step(1'b1, 16'sd3, 8'd192, "R3");
    for (int i = 0; i < 2 * DEPTH; i++) step(1'b1, (i % 2) ? 16'sh8000 : 16'sh7FFF, 8'(i * 37), "R3");
    flush("R3");
  endtask

  // Idle gaps between samples
  task automatic t_gaps();
    for (int i = 0; i < 2 * DEPTH; i++) begin
      step(1'b1, pat(i, 3), 8'(i * 11), "R6");
      for (int g = 0; g < (i % 3); g++) step(1'b0, pat(i, 9), 8'hAA, "R6");
    end
    flush("R6");
  endtask

  // Coefficient changes only in idle cycles must not matter
  task automatic t_coef_idle();
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, pat(i, 5), 8'd0, "R9");
      step(1'b1, pat(i, 4), 8'd200, "R9");
      step(1'b0, pat(i, 6), 8'd255, "R9");
    end
    flush("R9");
  endtask

  // k = 0: pure recirculation
  task automatic t_k0();
    for (int i = 0; i < 2 * DEPTH; i++) step(1'b1, pat(i, 7), 8'd0, "R8");
    flush("R8");
  endtask

  // Long unbroken run across several wraps
  task automatic t_wrap();
    for (int i = 0; i < 5 * DEPTH + 3; i++) step(1'b1, pat(i, 8), 8'(40 + i), "R7");
    flush("R7");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    ev[0] = 1'b0; ev[1] = 1'b0;
    eval_q[0] = 0; eval_q[1] = 0;
    t_reset();
    t_first_lap();
    t_feedback();
    t_round();
    t_gaps();
    t_coef_idle();
    t_k0();
    t_wrap();
    // Reset mid-run: memory must read as silence again
    for (int i = 0; i < 5; i++) step(1'b1, pat(i, 10), 8'd90, "R7");
    t_reset();
    t_first_lap();
    t_k0();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule